// File: doc/BRIEF.md
# Six-Slot Dual-Dispatch Instruction Queue

This block is a first-in first-out buffer between an instruction fetch port and a dispatch stage that can issue two instructions per cycle. Each cycle the fetcher offers up to four instruction words. The queue stores as many of them as fit once that cycle's dispatch has left. The two oldest words always sit in the two lowest slots, where dispatch reads them.

Downstream logic raises a per-slot ready signal. The queue removes the words it dispatches, in order, and shifts the survivors down. It publishes its current number of free slots. It also registers a fetch request size equal to the free-slot count seen one cycle earlier, limited to four, so the fetcher can size its next access. A flush input, raised on a branch misprediction, empties the queue in one cycle. A flush wins over any write or dispatch in the same cycle.

Top module: `instr_queue`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, the queue is empty: vacancy_o is 6, disp_valid_o is 0 and fetch_req_o is 4.
- R2: The number of words accepted in a cycle, fetch_acc_o, is the smaller of the offered count and the free slots left after that cycle's dispatch. An offered count above 4 counts as 4. Occupancy never exceeds 6.
- R3: Offered words are taken in order, lowest word (bits 31:0 of fetch_data_i) first. Accepted words are placed above the entries that survive that cycle's dispatch. No valid entry is overwritten, and first-in first-out order holds.
- R4: fetch_req_o equals min(vacancy_o of the previous cycle, 4). In the cycle after a flush it is 4.
- R5: disp_valid_o[0] is set when at least one entry is held, and disp_valid_o[1] when at least two are. disp_data_o bits 31:0 carry the oldest entry and bits 63:32 the next oldest.
- R6: Dispatch is in order. disp_fire_o[0] = disp_valid_o[0] & disp_ready_i[0]. disp_fire_o[1] = disp_fire_o[0] & disp_valid_o[1] & disp_ready_i[1]. At most two entries leave per cycle.
- R7: A slot-0 entry that is not dispatched is still in slot 0 in the next cycle, with the same data.
- R8: A flush_i cycle forces disp_fire_o and fetch_acc_o to 0. In the next cycle the queue is empty and vacancy_o is 6.
- R9: vacancy_o is 6 minus occupancy. Outside a flush, it changes each cycle by the number dispatched minus the number accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Misprediction flush, empties the queue |
| fetch_cnt_i | input | 3 | Number of words offered this cycle |
| fetch_data_i | input | 128 | Offered words, word k at bits 32k+31:32k |
| fetch_acc_o | output | 3 | Number of offered words stored this cycle |
| fetch_req_o | output | 3 | Registered fetch request size |
| vacancy_o | output | 3 | Free slots now |
| disp_valid_o | output | 2 | Slot 0 / slot 1 hold a valid entry |
| disp_data_o | output | 64 | Slot 0 word (low) and slot 1 word (high) |
| disp_ready_i | input | 2 | Downstream ready, per slot |
| disp_fire_o | output | 2 | Slot dispatched this cycle |

## Verification
disp_fire_o and fetch_acc_o follow combinationally from the inputs and the held state. They are due in the same cycle as the stimulus, so the bench reads them one time unit after it drives inputs on the falling edge. Occupancy, slot contents, disp_valid_o and vacancy_o move one rising edge later. fetch_req_o depends on the vacancy seen before that same edge, so it also reflects the stimulus one edge later. The bench samples all of these on the following falling edge and compares them with a reference queue kept in the bench. That reference covers a fixed vector table and a long run of random fetch, ready and flush patterns.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_DEPTH   = 6;
  localparam int unsigned IQ_FETCH_W = 4;
  localparam int unsigned IQ_DISP_W  = 2;
  localparam int unsigned IQ_WORD_W  = 32;

  function automatic int unsigned umin(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/iq_dispatch_ctl.sv
module iq_dispatch_ctl #(
  parameter int unsigned DEPTH  = iq_pkg::IQ_DEPTH,
  parameter int unsigned DISP_W = iq_pkg::IQ_DISP_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned DC_W  = $clog2(DISP_W + 1)
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flush_i,
  input  logic [DISP_W-1:0] ready_i,
  output logic [DISP_W-1:0] valid_o,
  output logic [DISP_W-1:0] fire_o,
  output logic [DC_W-1:0]   ndisp_o
);
  for (genvar j = 0; j < DISP_W; j++) begin : g_disp
    assign valid_o[j] = (int'(count_i) > j);
    if (j == 0) begin : g_head
      assign fire_o[j] = valid_o[j] & ready_i[j] & ~flush_i;
    end else begin : g_chain
      // in-order: a slot leaves only behind every older slot
      assign fire_o[j] = fire_o[j-1] & valid_o[j] & ready_i[j];
    end
  end

  always_comb begin
    ndisp_o = '0;
    for (int j = 0; j < DISP_W; j++) ndisp_o = ndisp_o + DC_W'(fire_o[j]);
  end
endmodule

// File: rtl/iq_occupancy.sv
module iq_occupancy #(
  parameter int unsigned DEPTH   = iq_pkg::IQ_DEPTH,
  parameter int unsigned FETCH_W = iq_pkg::IQ_FETCH_W,
  parameter int unsigned DISP_W  = iq_pkg::IQ_DISP_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned FC_W   = $clog2(FETCH_W + 1),
  localparam int unsigned DC_W   = $clog2(DISP_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [FC_W-1:0]  fetch_cnt_i,
  input  logic [DC_W-1:0]  ndisp_i,
  output logic [FC_W-1:0]  acc_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] vacancy_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W:0]   free_after;
  logic [FC_W-1:0]  fc;

  always_comb begin
    fc = (fetch_cnt_i > FC_W'(FETCH_W)) ? FC_W'(FETCH_W) : fetch_cnt_i;
    free_after = (CNT_W+1)'(DEPTH) - {1'b0, count_q} + (CNT_W+1)'(ndisp_i);
    if (flush_i)                         acc_o = '0;
    else if ((CNT_W+1)'(fc) < free_after) acc_o = fc;
    else                                 acc_o = FC_W'(free_after);
    count_d = flush_i ? '0 : count_q - CNT_W'(ndisp_i) + CNT_W'(acc_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o   = count_q;
  assign vacancy_o = CNT_W'(DEPTH) - count_q;
endmodule

// File: rtl/iq_fetch_req.sv
module iq_fetch_req #(
  parameter int unsigned DEPTH   = iq_pkg::IQ_DEPTH,
  parameter int unsigned FETCH_W = iq_pkg::IQ_FETCH_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned FC_W   = $clog2(FETCH_W + 1),
  localparam int unsigned REQ_MAX = iq_pkg::umin(DEPTH, FETCH_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] vacancy_i,
  output logic [FC_W-1:0]  req_o
);
  logic [FC_W-1:0] req_d;

  always_comb begin
    if (flush_i || vacancy_i > CNT_W'(REQ_MAX)) req_d = FC_W'(REQ_MAX);
    else                                        req_d = FC_W'(vacancy_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= FC_W'(REQ_MAX);
    else         req_o <= req_d;
  end
endmodule

// File: rtl/iq_storage.sv
module iq_storage #(
  parameter int unsigned DEPTH   = iq_pkg::IQ_DEPTH,
  parameter int unsigned FETCH_W = iq_pkg::IQ_FETCH_W,
  parameter int unsigned DISP_W  = iq_pkg::IQ_DISP_W,
  parameter int unsigned WORD_W  = iq_pkg::IQ_WORD_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned FC_W   = $clog2(FETCH_W + 1),
  localparam int unsigned DC_W   = $clog2(DISP_W + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CNT_W-1:0]          count_i,
  input  logic [DC_W-1:0]           ndisp_i,
  input  logic [FC_W-1:0]           acc_i,
  input  logic [FETCH_W*WORD_W-1:0] fetch_data_i,
  output logic [DISP_W*WORD_W-1:0]  slot_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] mem_d [DEPTH];
  logic [WORD_W-1:0] ext   [DEPTH+DISP_W];
  logic [CNT_W-1:0]  survivors;

  // zero-padded view so a shift past the top reads a defined value
  for (genvar k = 0; k < DEPTH + DISP_W; k++) begin : g_ext
    if (k < DEPTH) begin : g_real
      assign ext[k] = mem_q[k];
    end else begin : g_pad
      assign ext[k] = '0;
    end
  end

  assign survivors = count_i - CNT_W'(ndisp_i);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      for (int d = 0; d <= DISP_W; d++)
        if (int'(ndisp_i) == d) mem_d[i] = ext[i+d];
      // new words stack directly above the entries that stay
      for (int k = 0; k < FETCH_W; k++)
        if (int'(survivors) + k == i && k < int'(acc_i))
          mem_d[i] = fetch_data_i[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  for (genvar j = 0; j < DISP_W; j++) begin : g_slot_out
    assign slot_o[j*WORD_W +: WORD_W] = mem_q[j];
  end
endmodule

// File: rtl/instr_queue.sv
module instr_queue #(
  parameter int unsigned DEPTH   = iq_pkg::IQ_DEPTH,
  parameter int unsigned FETCH_W = iq_pkg::IQ_FETCH_W,
  parameter int unsigned DISP_W  = iq_pkg::IQ_DISP_W,
  parameter int unsigned WORD_W  = iq_pkg::IQ_WORD_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned FC_W   = $clog2(FETCH_W + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [FC_W-1:0]           fetch_cnt_i,
  input  logic [FETCH_W*WORD_W-1:0] fetch_data_i,
  output logic [FC_W-1:0]           fetch_acc_o,
  output logic [FC_W-1:0]           fetch_req_o,
  output logic [CNT_W-1:0]          vacancy_o,
  output logic [DISP_W-1:0]         disp_valid_o,
  output logic [DISP_W*WORD_W-1:0]  disp_data_o,
  input  logic [DISP_W-1:0]         disp_ready_i,
  output logic [DISP_W-1:0]         disp_fire_o
);
  localparam int unsigned DC_W = $clog2(DISP_W + 1);

  logic [CNT_W-1:0] count;
  logic [DC_W-1:0]  ndisp;

  iq_dispatch_ctl #(.DEPTH(DEPTH), .DISP_W(DISP_W)) u_disp (
    .count_i (count),
    .flush_i (flush_i),
    .ready_i (disp_ready_i),
    .valid_o (disp_valid_o),
    .fire_o  (disp_fire_o),
    .ndisp_o (ndisp)
  );

  iq_occupancy #(.DEPTH(DEPTH), .FETCH_W(FETCH_W), .DISP_W(DISP_W)) u_occ (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .fetch_cnt_i (fetch_cnt_i),
    .ndisp_i     (ndisp),
    .acc_o       (fetch_acc_o),
    .count_o     (count),
    .vacancy_o   (vacancy_o)
  );

  iq_fetch_req #(.DEPTH(DEPTH), .FETCH_W(FETCH_W)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .vacancy_i (vacancy_o),
    .req_o     (fetch_req_o)
  );

  iq_storage #(.DEPTH(DEPTH), .FETCH_W(FETCH_W), .DISP_W(DISP_W), .WORD_W(WORD_W)) u_mem (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .count_i      (count),
    .ndisp_i      (ndisp),
    .acc_i        (fetch_acc_o),
    .fetch_data_i (fetch_data_i),
    .slot_o       (disp_data_o)
  );
endmodule

// File: rtl/instr_queue_chk.sv
module instr_queue_chk #(
  parameter int unsigned DEPTH   = iq_pkg::IQ_DEPTH,
  parameter int unsigned FETCH_W = iq_pkg::IQ_FETCH_W,
  parameter int unsigned DISP_W  = iq_pkg::IQ_DISP_W,
  parameter int unsigned WORD_W  = iq_pkg::IQ_WORD_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned FC_W   = $clog2(FETCH_W + 1),
  localparam int unsigned REQ_MAX = iq_pkg::umin(DEPTH, FETCH_W)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     flush_i,
  input logic [FC_W-1:0]          fetch_cnt_i,
  input logic [FC_W-1:0]          fetch_acc_o,
  input logic [FC_W-1:0]          fetch_req_o,
  input logic [CNT_W-1:0]         vacancy_o,
  input logic [DISP_W-1:0]        disp_valid_o,
  input logic [DISP_W*WORD_W-1:0] disp_data_o,
  input logic [DISP_W-1:0]        disp_ready_i,
  input logic [DISP_W-1:0]        disp_fire_o
);
  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(vacancy_o) <= DEPTH);

  assert_acc_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_acc_o <= fetch_cnt_i && int'(fetch_acc_o) <= FETCH_W &&
    int'(fetch_acc_o) <= int'(vacancy_o) + $countones(disp_fire_o));

  assert_occupancy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> int'(vacancy_o) ==
      int'($past(vacancy_o)) + $countones($past(disp_fire_o)) - int'($past(fetch_acc_o)));

  assert_flush_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> int'(vacancy_o) == DEPTH && disp_valid_o == '0);

  assert_flush_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> disp_fire_o == '0 && fetch_acc_o == '0);

  assert_req_flush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> int'(fetch_req_o) == REQ_MAX);

  assert_req_vacancy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> int'(fetch_req_o) == iq_pkg::umin(int'($past(vacancy_o)), REQ_MAX));

  assert_fire_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_fire_o & ~(disp_valid_o & disp_ready_i)) == '0 &&
    ((disp_fire_o + 1'b1) & disp_fire_o) == '0);

  assert_valid_shape_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((disp_valid_o + 1'b1) & disp_valid_o) == '0 &&
    disp_valid_o[0] == (int'(vacancy_o) != DEPTH));

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o[0] && !disp_fire_o[0] && !flush_i |=>
      disp_valid_o[0] && $stable(disp_data_o[WORD_W-1:0]));
endmodule

bind instr_queue instr_queue_chk #(
  .DEPTH(DEPTH), .FETCH_W(FETCH_W), .DISP_W(DISP_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .fetch_cnt_i  (fetch_cnt_i),
  .fetch_acc_o  (fetch_acc_o),
  .fetch_req_o  (fetch_req_o),
  .vacancy_o    (vacancy_o),
  .disp_valid_o (disp_valid_o),
  .disp_data_o  (disp_data_o),
  .disp_ready_i (disp_ready_i),
  .disp_fire_o  (disp_fire_o)
);

// File: tb/sim_instr_queue.sv
module sim_instr_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;
  localparam int FW    = 4;
  localparam int WW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic [2:0]    fcnt = '0;
  logic [FW*WW-1:0] fdata = '0;
  logic [2:0]    acc, req, vac;
  logic [1:0]    dvalid, dready = '0, dfire;
  logic [2*WW-1:0] ddata;

  int checks = 0;
  int errors = 0;
  int mq [DEPTH];
  int mcnt = 0;
  int seq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_queue u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .fetch_cnt_i(fcnt), .fetch_data_i(fdata),
    .fetch_acc_o(acc), .fetch_req_o(req), .vacancy_o(vac),
    .disp_valid_o(dvalid), .disp_data_o(ddata),
    .disp_ready_i(dready), .disp_fire_o(dfire)
  );

  // {flush, fcnt, rdy, acc, fire, vac_after, req_after}
  localparam logic [16:0] TBL [12] = '{
    {1'b0, 3'd4, 2'b00, 3'd4, 2'b00, 3'd2, 3'd4},
    {1'b0, 3'd4, 2'b00, 3'd2, 2'b00, 3'd0, 3'd2},
    {1'b0, 3'd4, 2'b11, 3'd2, 2'b11, 3'd0, 3'd0},
    {1'b0, 3'd0, 2'b01, 3'd0, 2'b01, 3'd1, 3'd0},
    {1'b0, 3'd0, 2'b10, 3'd0, 2'b00, 3'd1, 3'd1},
    {1'b0, 3'd3, 2'b11, 3'd3, 2'b11, 3'd0, 3'd1},
    {1'b1, 3'd4, 2'b11, 3'd0, 2'b00, 3'd6, 3'd4},
    {1'b0, 3'd1, 2'b11, 3'd1, 2'b00, 3'd5, 3'd4},
    {1'b0, 3'd2, 2'b11, 3'd2, 2'b01, 3'd4, 3'd4},
    {1'b0, 3'd0, 2'b11, 3'd0, 2'b11, 3'd6, 3'd4},
    {1'b0, 3'd7, 2'b00, 3'd4, 2'b00, 3'd2, 3'd4},
    {1'b1, 3'd4, 2'b00, 3'd0, 2'b00, 3'd6, 3'd4}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // one cycle: drive at negedge, comb checks, edge, state checks at next negedge
  task automatic cycle(input bit f, input int c, input logic [1:0] r,
                       input bit use_tbl, input int t_acc, input int t_fire,
                       input int t_vac, input int t_req);
    int e_f0, e_f1, nd, e_acc, e_req, vac_before;
    flush = f; fcnt = 3'(c); dready = r;
    for (int k = 0; k < FW; k++) fdata[k*WW +: WW] = 32'h1000_0000 + 32'(seq + k);
    #1;
    e_f0 = (mcnt >= 1 && r[0] && !f) ? 1 : 0;
    e_f1 = (e_f0 == 1 && mcnt >= 2 && r[1]) ? 1 : 0;
    nd = e_f0 + e_f1;
    e_acc = f ? 0 : imin(imin(c, FW), DEPTH - mcnt + nd);
    vac_before = DEPTH - mcnt;
    e_req = f ? FW : imin(vac_before, FW);
    chk(int'(dfire) == e_f1*2 + e_f0, "R6 fire", int'(dfire), e_f1*2 + e_f0);
    chk(int'(acc) == e_acc, "R2 accepted", int'(acc), e_acc);
    chk(int'(dvalid) == ((mcnt >= 2) ? 3 : mcnt), "R5 valid", int'(dvalid), (mcnt >= 2) ? 3 : mcnt);
    for (int j = 0; j < 2; j++)
      if (j < mcnt) chk(int'(ddata[j*WW +: WW]) == mq[j], "R3/R7 slot data",
                        int'(ddata[j*WW +: WW]), mq[j]);
    if (use_tbl) begin
      chk(int'(dfire) == t_fire, "R6 table fire", int'(dfire), t_fire);
      chk(int'(acc) == t_acc, "R2 table accepted", int'(acc), t_acc);
    end
    @(posedge clk);
    if (f) mcnt = 0;
    else begin
      for (int j = 0; j < DEPTH; j++) if (j + nd < mcnt) mq[j] = mq[j + nd];
      mcnt = mcnt - nd;
      for (int k = 0; k < e_acc; k++) mq[mcnt + k] = 32'h1000_0000 + seq + k;
      mcnt = mcnt + e_acc;
      seq = seq + e_acc;
    end
    @(negedge clk);
    chk(int'(vac) == DEPTH - mcnt, f ? "R8 vacancy after flush" : "R9 vacancy",
        int'(vac), DEPTH - mcnt);
    chk(int'(req) == e_req, "R4 request", int'(req), e_req);
    if (use_tbl) begin
      chk(int'(vac) == t_vac, "R9 table vacancy", int'(vac), t_vac);
      chk(int'(req) == t_req, "R4 table request", int'(req), t_req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(vac) == 6, "R1 vacancy in reset", int'(vac), 6);
    chk(dvalid == 2'b00, "R1 valid in reset", int'(dvalid), 0);
    chk(int'(req) == 4, "R1 request in reset", int'(req), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(vac) == 6 && dvalid == 2'b00, "R1 empty after release", int'(vac), 6);

    for (int i = 0; i < 12; i++)
      cycle(TBL[i][16], int'(TBL[i][15:13]), TBL[i][12:11], 1'b1,
            int'(TBL[i][10:8]), int'(TBL[i][7:6]), int'(TBL[i][5:3]), int'(TBL[i][2:0]));

    // R7 directed: fill, stall slot 0 for several cycles
    cycle(1'b0, 4, 2'b00, 1'b0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      cycle(1'b0, 0, 2'b10, 1'b0, 0, 0, 0, 0);
      chk(int'(ddata[WW-1:0]) == mq[0], "R7 stalled slot 0 held", int'(ddata[WW-1:0]), mq[0]);
    end
    // R8 flush on a full queue with offers and ready
    cycle(1'b0, 4, 2'b00, 1'b0, 0, 0, 0, 0);
    cycle(1'b1, 4, 2'b11, 1'b0, 0, 0, 0, 0);
    chk(dvalid == 2'b00, "R8 empty after flush", int'(dvalid), 0);

    // random patterns against the reference queue
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 16) == 0, int'($urandom % 8), 2'($urandom), 1'b0, 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule